// File: doc/BRIEF.md
# Vector Gather-Scatter Memory Sequencer

This block carries out one gather load or one scatter store on a 128-bit vector register. A command supplies a 32-bit scalar base, an offset vector, a data vector and two 16-bit masks: a per-byte predicate and a per-byte beat-execution mask. For a store, the data vector is the source. For a load, it is the previous destination contents.

The data vector is cut into lanes of 1, 2 or 4 bytes. A doubleword operation uses 4-byte halves. Each lane's address is the base plus that lane's offset, and the offset can be scaled by the memory access size. The sequencer walks the lanes in ascending order and issues at most one 32-bit memory access per lane on a request/acknowledge port. On loads it sign- or zero-extends narrow memory data into the lane. When all lanes are finished it returns the new vector with a one-cycle done pulse.

Illegal combinations of sizes, signedness, scaling and register indices are flagged, and such a command makes no memory access.

The command side is a valid/ready handshake. `cmd_ready` is high only while the sequencer is idle, and a command is taken on any clock edge where `cmd_valid` and `cmd_ready` are both high. On the memory side, `mem_req` and its address, size, write-enable and write data stay stable until the memory answers with `mem_ack`. A load's `mem_rdata` is sampled in the acknowledge cycle. The memory can stall for any number of cycles.

Top module: `gather_scatter_seq`

## Requirements
- R1: After a synchronous reset the block is idle: `cmd_ready`=1, `mem_req`=0, `done`=0 and `result`=0.
- R2: A lane's address is `cmd_base` plus that lane's offset. The offset is the unsigned offset-vector element of the lane's width, at the same position as the lane, where lane i of width w bytes occupies bits [8*w*i +: 8*w]. The sum wraps modulo 2^32.
- R3: When `cmd_scaled`=1, the offset is shifted left by the memory size code before it is added. Size codes are 0=byte, 1=halfword, 2=word, 3=doubleword, so the shift is 1, 2 or 3.
- R4: Lanes are processed in ascending order with one request outstanding at a time. A request is held stable until it is acknowledged. `done` is a single-cycle pulse that follows the last lane, with no request outstanding.
- R5: A lane is enabled by the predicate bit at its lowest byte (bit i*w). On a load, a disabled lane receives zero and makes no memory access.
- R6: On a store, a lane whose predicate bit is clear makes no memory write.
- R7: On a load, a lane whose beat-execution bit (bit i*w) is clear makes no access and keeps its previous value. Stores ignore the beat-execution mask.
- R8: With memory size and lane size both 3, the vector is handled as four 32-bit lanes. Lanes 2k and 2k+1 both use the 32-bit offset element 2k. The odd lane adds 4 to the address. Each half is gated by its own predicate and beat bits.
- R9: On a load narrower than the lane, data is sign-extended when `cmd_signed`=1 and zero-extended otherwise. Memory data is little-endian, so the lowest address lands in the least significant byte.
- R10: Each access has `mem_size` equal to the memory size (2 for doubleword halves). A store carries the low memory-size bytes of the lane in the low bits of `mem_wdata`, and the upper bits are zero.
- R11: These combinations are illegal:
  - memory size larger than lane size;
  - size 3 on only one of memory size and lane size;
  - scaling with byte memory size;
  - a signed load unless memory size is below lane size and lane size is at most word.

  An illegal command pulses `illegal` together with `done`, makes no memory access and returns `result` = `cmd_data`. `cmd_signed` is ignored on stores.
- R12: A load whose destination index equals its offset index is illegal, and so is any command whose base index is 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Sequencer idle, command accepted when valid |
| cmd_store | input | 1 | 1 = scatter store, 0 = gather load |
| cmd_signed | input | 1 | Sign-extend load data |
| cmd_scaled | input | 1 | Scale offsets by memory size |
| cmd_msize | input | 2 | Memory access size code |
| cmd_esize | input | 2 | Lane size code |
| cmd_dst_idx | input | 3 | Destination/data vector register index |
| cmd_off_idx | input | 3 | Offset vector register index |
| cmd_base_idx | input | 4 | Base scalar register index |
| cmd_base | input | 32 | Base address |
| cmd_offsets | input | 128 | Offset vector |
| cmd_data | input | 128 | Store source or previous load destination |
| cmd_pred | input | 16 | Per-byte predicate mask |
| cmd_beat | input | 16 | Per-byte beat-execution mask |
| mem_req | output | 1 | Memory request |
| mem_ack | input | 1 | Memory acknowledge |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request address |
| mem_size | output | 2 | Request size code |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| done | output | 1 | Operation finished pulse |
| illegal | output | 1 | Command was illegal, with `done` |
| result | output | 128 | Resulting vector |

## Verification
The bench uses the default parameters: a 16-byte vector, a 32-bit address, 3-bit vector indices and 4-bit scalar indices. With these defaults all four size codes can be exercised, as can 16-, 8- and 4-lane walks and the base index 15 that is rejected. A base near 2^32 reaches the address wrap. The memory model answers after 0 to 3 wait cycles and returns address-derived bytes with both sign states, so request holding and extension are both exercised.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_D = 2'd3} sz_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} seq_st_e;

  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    size_mask = 32'h0000_00FF;
      2'd1:    size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/sg_decode.sv
module sg_decode #(
  parameter int VBYTES = 16,
  parameter int QIDX_W = 3,
  parameter int RIDX_W = 4,
  parameter int IDX_W  = 5
) (
  input  logic              store,
  input  logic              sgn,
  input  logic              scaled,
  input  logic [1:0]        ms,
  input  logic [1:0]        es,
  input  logic [QIDX_W-1:0] dq,
  input  logic [QIDX_W-1:0] oq,
  input  logic [RIDX_W-1:0] bq,
  output logic              bad,
  output logic              dbl,
  output logic [1:0]        ll,
  output logic [1:0]        shamt,
  output logic [IDX_W-1:0]  nlanes
);
  logic bad_size, bad_scale, bad_sign, bad_reg;

  always_comb begin
    dbl       = (ms == 2'd3) && (es == 2'd3);
    bad_size  = ((ms == 2'd3) != (es == 2'd3)) || (ms > es);
    bad_scale = scaled && (ms == 2'd0);
    bad_sign  = !store && sgn && !((ms < es) && (es <= 2'd2));
    bad_reg   = (!store && (dq == oq)) || (bq == {RIDX_W{1'b1}});
    bad       = bad_size || bad_scale || bad_sign || bad_reg;
    ll        = dbl ? 2'd2 : es;
    shamt     = scaled ? ms : 2'd0;
    nlanes    = IDX_W'(VBYTES >> ll);
  end
endmodule

// File: rtl/sg_lane_pick.sv
module sg_lane_pick #(
  parameter int VBYTES = 16,
  parameter int IDX_W  = 5
) (
  input  logic [VBYTES*8-1:0] vec,
  input  logic [IDX_W-1:0]    idx,
  input  logic [1:0]          ll,
  output logic [31:0]         val
);
  localparam int SH_W = IDX_W + 5;
  logic [SH_W-1:0] bitpos;
  logic [31:0]     low;

  always_comb begin
    bitpos = SH_W'({idx, 3'b000}) << ll;
    low    = 32'(vec >> bitpos);
    case (ll)
      2'd0:    val = {24'b0, low[7:0]};
      2'd1:    val = {16'b0, low[15:0]};
      default: val = low;
    endcase
  end
endmodule

// File: rtl/sg_lane_ext.sv
module sg_lane_ext (
  input  logic [31:0] rdata,
  input  logic [1:0]  sz,
  input  logic        sgn,
  output logic [31:0] val
);
  always_comb begin
    case (sz)
      2'd0:    val = sgn ? {{24{rdata[7]}}, rdata[7:0]}   : {24'b0, rdata[7:0]};
      2'd1:    val = sgn ? {{16{rdata[15]}}, rdata[15:0]} : {16'b0, rdata[15:0]};
      default: val = rdata;
    endcase
  end
endmodule

// File: rtl/gather_scatter_seq.sv
module gather_scatter_seq
  import sg_pkg::*;
#(
  parameter int VBYTES = 16,
  parameter int AW     = 32,
  parameter int QIDX_W = 3,
  parameter int RIDX_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_store,
  input  logic                cmd_signed,
  input  logic                cmd_scaled,
  input  logic [1:0]          cmd_msize,
  input  logic [1:0]          cmd_esize,
  input  logic [QIDX_W-1:0]   cmd_dst_idx,
  input  logic [QIDX_W-1:0]   cmd_off_idx,
  input  logic [RIDX_W-1:0]   cmd_base_idx,
  input  logic [AW-1:0]       cmd_base,
  input  logic [VBYTES*8-1:0] cmd_offsets,
  input  logic [VBYTES*8-1:0] cmd_data,
  input  logic [VBYTES-1:0]   cmd_pred,
  input  logic [VBYTES-1:0]   cmd_beat,
  output logic                mem_req,
  input  logic                mem_ack,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [1:0]          mem_size,
  output logic [31:0]         mem_wdata,
  input  logic [31:0]         mem_rdata,
  output logic                done,
  output logic                illegal,
  output logic [VBYTES*8-1:0] result
);
  localparam int VBITS = VBYTES * 8;
  localparam int IDX_W = $clog2(VBYTES) + 1;
  localparam int POS_W = $clog2(VBYTES);

  seq_st_e             st;
  logic                is_st, is_sg, is_sc;
  logic [1:0]          ms, es;
  logic [QIDX_W-1:0]   dq, oq;
  logic [RIDX_W-1:0]   bq;
  logic [AW-1:0]       base;
  logic [VBITS-1:0]    offs, vreg, vreg_nx;
  logic [VBYTES-1:0]   pred, beat;
  logic [IDX_W-1:0]    idx, off_idx;
  logic                done_q, ill_q;

  logic                bad, dbl;
  logic [1:0]          ll, shamt, acc_sz;
  logic [IDX_W-1:0]    nlanes;
  logic [POS_W-1:0]    pos;
  logic                finish, take, en, access, step, wr_lane;
  logic [31:0]         off_raw, lane_raw, ld_val, wr_val;

  sg_decode #(.VBYTES(VBYTES), .QIDX_W(QIDX_W), .RIDX_W(RIDX_W), .IDX_W(IDX_W)) u_dec (
    .store(is_st), .sgn(is_sg), .scaled(is_sc), .ms(ms), .es(es),
    .dq(dq), .oq(oq), .bq(bq),
    .bad(bad), .dbl(dbl), .ll(ll), .shamt(shamt), .nlanes(nlanes)
  );

  // Offset element: doubleword halves share the even element of their pair.
  assign off_idx = dbl ? {idx[IDX_W-1:1], 1'b0} : idx;

  sg_lane_pick #(.VBYTES(VBYTES), .IDX_W(IDX_W)) u_off_pick (
    .vec(offs), .idx(off_idx), .ll(ll), .val(off_raw)
  );

  sg_lane_pick #(.VBYTES(VBYTES), .IDX_W(IDX_W)) u_dat_pick (
    .vec(vreg), .idx(idx), .ll(ll), .val(lane_raw)
  );

  assign acc_sz = dbl ? 2'd2 : ms;

  sg_lane_ext u_ext (
    .rdata(mem_rdata), .sz(acc_sz), .sgn(is_sg), .val(ld_val)
  );

  always_comb begin
    finish  = bad || (idx == nlanes);
    pos     = POS_W'(idx << ll);
    take    = is_st || beat[pos];
    en      = pred[pos];
    access  = (st == ST_RUN) && !finish && take && en;
    step    = (st == ST_RUN) && !finish && (!(take && en) || mem_ack);
    wr_lane = step && !is_st && take;
    wr_val  = en ? ld_val : 32'd0;
  end

  always_comb begin
    vreg_nx = vreg;
    for (int b = 0; b < VBYTES; b++) begin
      if (wr_lane && ((IDX_W'(b) >> ll) == idx))
        vreg_nx[b*8 +: 8] = wr_val[8*(b & ((1 << ll) - 1)) +: 8];
    end
  end

  assign mem_req   = access;
  assign mem_we    = access && is_st;
  assign mem_size  = acc_sz;
  assign mem_addr  = base + (AW'(off_raw) << shamt) + ((dbl && idx[0]) ? AW'(4) : AW'(0));
  assign mem_wdata = lane_raw & size_mask(acc_sz);

  assign cmd_ready = (st == ST_IDLE);
  assign done      = done_q;
  assign illegal   = done_q && ill_q;
  assign result    = vreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      idx    <= '0;
      vreg   <= '0;
      is_st  <= 1'b0;
      is_sg  <= 1'b0;
      is_sc  <= 1'b0;
      ms     <= 2'd0;
      es     <= 2'd0;
      dq     <= '0;
      oq     <= '0;
      bq     <= '0;
      base   <= '0;
      offs   <= '0;
      pred   <= '0;
      beat   <= '0;
    end else begin
      done_q <= 1'b0;
      if (st == ST_IDLE) begin
        if (cmd_valid) begin
          st    <= ST_RUN;
          idx   <= '0;
          is_st <= cmd_store;
          is_sg <= cmd_signed;
          is_sc <= cmd_scaled;
          ms    <= cmd_msize;
          es    <= cmd_esize;
          dq    <= cmd_dst_idx;
          oq    <= cmd_off_idx;
          bq    <= cmd_base_idx;
          base  <= cmd_base;
          offs  <= cmd_offsets;
          vreg  <= cmd_data;
          pred  <= cmd_pred;
          beat  <= cmd_beat;
        end
      end else begin
        vreg <= vreg_nx;
        if (finish) begin
          st     <= ST_IDLE;
          done_q <= 1'b1;
          ill_q  <= bad;
        end else if (step) begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sg_seq_chk.sv
module sg_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_ready,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          done,
  input logic          illegal
);
  logic req_seen;

  always_ff @(posedge clk) begin
    if (rst || done) req_seen <= 1'b0;
    else if (mem_req) req_seen <= 1'b1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cmd_ready && !mem_req && !done));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req);

  // R11
  illegal_noacc_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !req_seen);
endmodule

bind gather_scatter_seq sg_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_we(mem_we), .mem_addr(mem_addr),
  .done(done), .illegal(illegal)
);

// File: tb/gather_scatter_seq_test.sv
`timescale 1ns/1ps
module gather_scatter_seq_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_ready;
  logic cmd_store = 0, cmd_signed = 0, cmd_scaled = 0;
  logic [1:0] cmd_msize = 0, cmd_esize = 0;
  logic [2:0] cmd_dst_idx = 0, cmd_off_idx = 0;
  logic [3:0] cmd_base_idx = 0;
  logic [31:0] cmd_base = 0;
  logic [127:0] cmd_offsets = 0, cmd_data = 0;
  logic [15:0] cmd_pred = 0, cmd_beat = 0;
  logic mem_req, mem_ack = 1'b0, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic [1:0] mem_size;
  logic done, illegal;
  logic [127:0] result;

  int checks = 0, failures = 0, ack_lat = 0, lat_cnt = 0;
  logic [31:0] log_addr [16];
  logic [31:0] log_wd [16];
  logic [1:0]  log_sz [16];
  logic        log_we [16];
  int          log_n = 0;

  always #2.5 clk = ~clk;

  gather_scatter_seq uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_store(cmd_store), .cmd_signed(cmd_signed), .cmd_scaled(cmd_scaled),
    .cmd_msize(cmd_msize), .cmd_esize(cmd_esize), .cmd_dst_idx(cmd_dst_idx),
    .cmd_off_idx(cmd_off_idx), .cmd_base_idx(cmd_base_idx), .cmd_base(cmd_base),
    .cmd_offsets(cmd_offsets), .cmd_data(cmd_data), .cmd_pred(cmd_pred),
    .cmd_beat(cmd_beat), .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done), .illegal(illegal), .result(result)
  );

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h3C;
  endfunction

  function automatic logic [31:0] mword(input logic [31:0] a);
    return {mbyte(a + 32'd3), mbyte(a + 32'd2), mbyte(a + 32'd1), mbyte(a)};
  endfunction

  // memory responder with programmable wait cycles
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        if (lat_cnt >= ack_lat) begin
          if (log_n < 16) begin
            log_addr[log_n] = mem_addr;
            log_wd[log_n]   = mem_wdata;
            log_sz[log_n]   = mem_size;
            log_we[log_n]   = mem_we;
          end
          log_n++;
          mem_rdata = mword(mem_addr);
          mem_ack   = 1'b1;
          lat_cnt   = 0;
        end else begin
          lat_cnt++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic run_op(input string tag, input bit st, input bit sg, input bit sc,
                        input bit [1:0] ms, input bit [1:0] es,
                        input bit [2:0] dq, input bit [2:0] oq, input bit [3:0] bq,
                        input bit [31:0] base, input bit [127:0] offs,
                        input bit [127:0] dat, input bit [15:0] pr, input bit [15:0] bt);
    bit ill, dbl;
    int lb, nl, ne, pb, oi, wd;
    bit [31:0] off, a, w, rd, v;
    bit [1:0] sz;
    bit [31:0] ea [16];
    bit [31:0] ew [16];
    bit [1:0]  esz [16];
    bit [127:0] er;
    dbl = (ms == 3) && (es == 3);
    ill = ((ms == 3) != (es == 3)) || (ms > es) || (sc && ms == 0) ||
          (!st && sg && !((ms < es) && (es <= 2))) || (!st && dq == oq) || (bq == 4'd15);
    lb = dbl ? 4 : (1 << es);
    nl = 16 / lb;
    ne = 0;
    er = dat;
    if (!ill) begin
      for (int i = 0; i < nl; i++) begin
        pb = i * lb;
        if (!st && !bt[pb]) continue;
        if (!pr[pb]) begin
          if (!st) for (int k = 0; k < lb; k++) er[(pb + k)*8 +: 8] = 8'h00;
          continue;
        end
        oi = dbl ? (i & ~1) : i;
        off = 0;
        for (int k = 0; k < lb; k++) off[k*8 +: 8] = offs[(oi*lb + k)*8 +: 8];
        a = base + (off << (sc ? ms : 2'd0)) + ((dbl && (i % 2 == 1)) ? 32'd4 : 32'd0);
        sz = dbl ? 2'd2 : ms;
        ea[ne] = a;
        esz[ne] = sz;
        ew[ne] = 0;
        if (st) begin
          w = 0;
          for (int k = 0; k < (1 << sz); k++) w[k*8 +: 8] = dat[(pb + k)*8 +: 8];
          ew[ne] = w;
        end else begin
          rd = mword(a);
          case (sz)
            2'd0: v = sg ? {{24{rd[7]}}, rd[7:0]} : {24'b0, rd[7:0]};
            2'd1: v = sg ? {{16{rd[15]}}, rd[15:0]} : {16'b0, rd[15:0]};
            default: v = rd;
          endcase
          for (int k = 0; k < lb; k++) er[(pb + k)*8 +: 8] = v[k*8 +: 8];
        end
        ne++;
      end
    end
    log_n = 0;
    @(negedge clk);
    cmd_store = st; cmd_signed = sg; cmd_scaled = sc; cmd_msize = ms; cmd_esize = es;
    cmd_dst_idx = dq; cmd_off_idx = oq; cmd_base_idx = bq; cmd_base = base;
    cmd_offsets = offs; cmd_data = dat; cmd_pred = pr; cmd_beat = bt;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wd = 0;
    while (!done && wd < 3000) begin
      @(negedge clk);
      wd++;
    end
    chk(done === 1'b1, tag, "done seen (watchdog)", {127'b0, done}, 128'd1);
    chk(illegal === ill, tag, "illegal flag", {127'b0, illegal}, {127'b0, ill});
    chk(log_n == ne, tag, "access count", 128'(log_n), 128'(ne));
    for (int j = 0; j < ne && j < log_n && j < 16; j++) begin
      chk(log_addr[j] === ea[j], tag, $sformatf("lane access %0d addr", j),
          128'(log_addr[j]), 128'(ea[j]));
      chk(log_sz[j] === esz[j] && log_we[j] === st, tag,
          $sformatf("access %0d size/we", j),
          {125'b0, log_we[j], log_sz[j]}, {125'b0, st, esz[j]});
      if (st)
        chk(log_wd[j] === ew[j], tag, $sformatf("access %0d wdata", j),
            128'(log_wd[j]), 128'(ew[j]));
    end
    chk(result === er, tag, "result vector", result, er);
    @(negedge clk);
    chk(done === 1'b0, tag, "done single pulse", {127'b0, done}, 128'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(cmd_ready === 1'b1 && mem_req === 1'b0 && done === 1'b0, "R1", "idle after reset",
        {125'b0, cmd_ready, mem_req, done}, 128'b100);
    chk(result === 128'd0, "R1", "result after reset", result, 128'd0);
  endtask

  task automatic t_word_load;
    ack_lat = 1;
    run_op("R2 R4", 0, 0, 0, 2, 2, 1, 2, 3, 32'h0000_1000,
           {32'h0000_0300, 32'h0000_0020, 32'h0000_0104, 32'h0000_0000},
           {4{32'hDEAD_BEEF}}, 16'hFFFF, 16'hFFFF);
  endtask

  task automatic t_wrap;
    ack_lat = 0;
    run_op("R2 wrap", 0, 0, 0, 2, 2, 1, 2, 3, 32'hFFFF_FFF8,
           {32'h0000_0010, 32'h0000_000C, 32'h0000_0004, 32'h0000_0000},
           128'd0, 16'hFFFF, 16'hFFFF);
  endtask

  task automatic t_scaled;
    ack_lat = 2;
    run_op("R3 half", 0, 0, 1, 1, 1, 0, 4, 2, 32'h0000_2000,
           {16'h0007, 16'h0100, 16'h0005, 16'h0004, 16'h0003, 16'h0002, 16'h8001, 16'h0000},
           128'd0, 16'hFFFF, 16'hFFFF);
    run_op("R3 word", 0, 0, 1, 2, 2, 0, 4, 2, 32'h0000_3000,
           {32'h0000_0003, 32'h4000_0002, 32'h0000_0001, 32'h0000_0000},
           128'd0, 16'hFFFF, 16'hFFFF);
  endtask

  task automatic t_bytes;
    ack_lat = 0;
    run_op("R5", 0, 0, 0, 0, 0, 5, 6, 1, 32'h0001_0040,
           128'h0F0E_0D0C_0B0A_0908_0706_0504_0302_0100,
           {16{8'hEE}}, 16'hA5C3, 16'hFFFF);
    run_op("R7 load", 0, 0, 0, 0, 1, 5, 6, 1, 32'h0001_0800,
           {16'h0070, 16'h0060, 16'h0050, 16'h0040, 16'h0030, 16'h0020, 16'h0010, 16'h0000},
           {8{16'h1234}}, 16'hFFFF, 16'h0FF0);
  endtask

  task automatic t_extend;
    ack_lat = 1;
    run_op("R9 sbyte", 0, 1, 0, 0, 1, 2, 3, 4, 32'h0000_5080,
           {16'h0007, 16'h0006, 16'h0085, 16'h0004, 16'h0003, 16'h00C2, 16'h0001, 16'h0000},
           128'd0, 16'hFFFF, 16'hFFFF);
    run_op("R9 shalf", 0, 1, 1, 1, 2, 2, 3, 4, 32'h0000_6000,
           {32'h0000_0043, 32'h0000_0082, 32'h0000_00C1, 32'h0000_0000},
           128'd0, 16'hFFFF, 16'hFFFF);
    run_op("R9 ubyte", 0, 0, 0, 0, 2, 2, 3, 4, 32'h0000_6090,
           {32'h0000_0003, 32'h0000_0042, 32'h0000_00C1, 32'h0000_0000},
           128'd0, 16'hFFFF, 16'hFFFF);
  endtask

  task automatic t_store;
    ack_lat = 3;
    run_op("R6 R7 R10", 1, 1, 0, 1, 2, 3, 3, 0, 32'h0000_7000,
           {32'h0000_0030, 32'h0000_0020, 32'h0000_0010, 32'h0000_0000},
           {32'hA1A2_A3A4, 32'hB1B2_B3B4, 32'hC1C2_C3C4, 32'hD1D2_D3D4},
           16'hF0FF, 16'h0000);
    ack_lat = 0;
    run_op("R6 bytes", 1, 0, 0, 0, 0, 1, 2, 0, 32'h0000_7100,
           128'h1F1E_1D1C_1B1A_1918_1716_1514_1312_1110,
           128'h0F0E_0D0C_0B0A_0908_0706_0504_0302_0100,
           16'h5555, 16'hFFFF);
  endtask

  task automatic t_double;
    ack_lat = 1;
    run_op("R8 load", 0, 0, 1, 3, 3, 0, 1, 2, 32'h0000_8000,
           {32'hFFFF_FFFF, 32'h0000_0020, 32'h1234_5678, 32'h0000_0010},
           {4{32'h5555_AAAA}}, 16'hF00F, 16'hFFFF);
    run_op("R8 beat", 0, 0, 0, 3, 3, 0, 1, 2, 32'h0000_8100,
           {32'h0, 32'h0000_0040, 32'h0, 32'h0000_0008},
           {4{32'h7777_8888}}, 16'hFFFF, 16'h0FF0);
    run_op("R8 store", 1, 0, 0, 3, 3, 0, 0, 2, 32'h0000_8200,
           {32'hDEAD_0000, 32'h0000_0018, 32'hBEEF_0000, 32'h0000_0000},
           {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111},
           16'hFFFF, 16'h0000);
  endtask

  task automatic t_illegal;
    bit [127:0] d = 128'hCAFE_F00D_0123_4567_89AB_CDEF_0011_2233;
    ack_lat = 0;
    run_op("R11 ms>es", 0, 0, 0, 2, 1, 0, 1, 2, 32'h100, 128'd0, d, 16'hFFFF, 16'hFFFF);
    run_op("R11 scaled byte", 1, 0, 1, 0, 2, 0, 1, 2, 32'h100, 128'd0, d, 16'hFFFF, 16'hFFFF);
    run_op("R11 signed word", 0, 1, 0, 2, 2, 0, 1, 2, 32'h100, 128'd0, d, 16'hFFFF, 16'hFFFF);
    run_op("R11 dbl mismatch", 0, 0, 0, 3, 2, 0, 1, 2, 32'h100, 128'd0, d, 16'hFFFF, 16'hFFFF);
    run_op("R11 es3 ms2", 1, 0, 0, 2, 3, 0, 1, 2, 32'h100, 128'd0, d, 16'hFFFF, 16'hFFFF);
    run_op("R12 dst=off", 0, 0, 0, 2, 2, 3, 3, 2, 32'h100, 128'd0, d, 16'hFFFF, 16'hFFFF);
    run_op("R12 base15", 1, 0, 0, 2, 2, 0, 1, 15, 32'h100, 128'd0, d, 16'hFFFF, 16'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_word_load();
    t_wrap();
    t_scaled();
    t_bytes();
    t_extend();
    t_store();
    t_double();
    t_illegal();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule